// File: doc/BRIEF.md
# Descending Hardware Stack Pointer

This block keeps an 8-bit stack pointer together with the byte-wide stack storage that the pointer addresses. A processor core uses it to save return addresses, status bytes and temporary values. The stack grows downward. When the stack is empty the pointer holds its highest value, `$FF` with the default parameters. A push stores its byte at the location the pointer names and then moves the pointer down by one. A pop first moves the pointer up by one and then returns the byte found at the new location.

A transfer instruction can overwrite the pointer directly through a load port. The pointer value is always visible on an output so that it can be copied into a register. A pop from the empty stack does not wrap the pointer. The block refuses it and raises an underflow pulse. Requests that arrive together are refused as well, and a conflict pulse is raised.

All requests are sampled on the rising clock edge. The pointer, the read data and the one-cycle status pulses change at that edge.

Top module: `desc_stack`

## Requirements
- R1: While reset is high and after it is released, the pointer reads all ones (`$FF`) and the read data is zero. The valid, underflow and conflict outputs are low.
- R2: A lone push writes `wdata_i` to the location the pointer addresses, and the pointer drops by one on the same edge.
- R3: A lone pop with the pointer below all ones raises the pointer by one. `rdata_o` then shows the byte stored at the new pointer, and `rvalid_o` is high for exactly the following cycle.
- R4: Bytes come back in reverse order of pushing. After pushing `$AB`, `$CD` and `$EF` from `$FF`, the pointer reads `$FC`. Three pops then return `$EF`, `$CD` and `$AB`, and the pointer is back at `$FF`.
- R5: A pop while the pointer is all ones leaves the pointer unchanged and keeps `rvalid_o` low. `underflow_o` is high for the following cycle.
- R6: Two or more of push, pop and load in the same cycle are refused. The pointer is held, nothing is written, `rvalid_o` stays low, and `conflict_o` is high for the following cycle.
- R7: A lone load copies `load_val_i` into the pointer on the next edge and raises neither `underflow_o` nor `conflict_o`.
- R8: A push while the pointer is `$00` stores its byte and wraps the pointer to all ones without any error pulse.
- R9: In a cycle with no request, the pointer and `rdata_o` keep their values and all three pulse outputs are low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge active |
| rst | input | 1 | Synchronous reset, active high |
| push_i | input | 1 | Push request |
| pop_i | input | 1 | Pop request |
| wdata_i | input | DATA_W | Byte to push |
| load_i | input | 1 | Load the pointer directly |
| load_val_i | input | PTR_W | New pointer value for a load |
| ptr_o | output | PTR_W | Current pointer |
| rdata_o | output | DATA_W | Byte returned by the last valid pop |
| rvalid_o | output | 1 | One-cycle pulse: `rdata_o` holds fresh pop data |
| underflow_o | output | 1 | One-cycle pulse: pop refused on an empty stack |
| conflict_o | output | 1 | One-cycle pulse: simultaneous requests refused |

## Verification
The bench builds the block with its default widths: an 8-bit pointer and 8-bit data, which gives a 256-entry store. At this size the exact `$FF`/`$FC` values of R4 can be checked. The bench can also fill the whole store with 255 pushes, pop them all back to confirm reverse order, and reach the empty boundary for R5. The load port moves the pointer directly to `$00` for the wrap case of R8, and to chosen locations so that it can show that a refused request left memory unchanged.

// File: rtl/stk_pkg.sv
package stk_pkg;

    localparam int STK_PTR_W_DEF  = 8;
    localparam int STK_DATA_W_DEF = 8;

    // Operation chosen for one cycle
    typedef enum logic [2:0] {
        OP_IDLE  = 3'd0,
        OP_PUSH  = 3'd1,
        OP_POP   = 3'd2,
        OP_LOAD  = 3'd3,
        OP_UNDER = 3'd4,
        OP_CLASH = 3'd5
    } stk_op_e;

    // Pulse outputs registered after each cycle
    typedef struct packed {
        logic rd_valid;
        logic underflow;
        logic clash;
    } stk_flags_t;

    function automatic stk_op_e stk_classify(input logic push,
                                             input logic pop,
                                             input logic load,
                                             input logic empty);
        int reqs;
        stk_op_e op;
        reqs = int'(push) + int'(pop) + int'(load);
        if (reqs > 1)      op = OP_CLASH;
        else if (push)     op = OP_PUSH;
        else if (pop)      op = empty ? OP_UNDER : OP_POP;
        else if (load)     op = OP_LOAD;
        else               op = OP_IDLE;
        return op;
    endfunction

    function automatic stk_flags_t stk_flags_of(input stk_op_e op);
        stk_flags_t f;
        f.rd_valid  = (op == OP_POP);
        f.underflow = (op == OP_UNDER);
        f.clash     = (op == OP_CLASH);
        return f;
    endfunction

endpackage

// File: rtl/stk_ptr_ctrl.sv
module stk_ptr_ctrl
    import stk_pkg::*;
#(
    parameter int PTR_W = STK_PTR_W_DEF
) (
    input  logic             clk,
    input  logic             rst,
    input  stk_op_e          op,
    input  logic [PTR_W-1:0] load_val,
    output logic [PTR_W-1:0] ptr,
    output logic [PTR_W-1:0] ptr_up,
    output logic             empty
);

    localparam logic [PTR_W-1:0] EMPTY_PTR = '1;
    localparam logic [PTR_W-1:0] ONE       = PTR_W'(1);

    logic [PTR_W-1:0] ptr_nxt;

    assign ptr_up = ptr + ONE;
    assign empty  = (ptr == EMPTY_PTR);

    always_comb begin
        unique case (op)
            OP_PUSH: ptr_nxt = ptr - ONE;
            OP_POP:  ptr_nxt = ptr_up;
            OP_LOAD: ptr_nxt = load_val;
            default: ptr_nxt = ptr;
        endcase
    end

    always_ff @(posedge clk) begin
        if (rst) ptr <= EMPTY_PTR;
        else     ptr <= ptr_nxt;
    end

endmodule

// File: rtl/stk_mem.sv
module stk_mem
    import stk_pkg::*;
#(
    parameter int DATA_W = STK_DATA_W_DEF,
    parameter int ADDR_W = STK_PTR_W_DEF
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              we,
    input  logic [ADDR_W-1:0] waddr,
    input  logic [DATA_W-1:0] wdata,
    input  logic              re,
    input  logic [ADDR_W-1:0] raddr,
    output logic [DATA_W-1:0] rdata
);

    localparam int DEPTH = 1 << ADDR_W;

    logic [DATA_W-1:0] cells [DEPTH];

    always_ff @(posedge clk) begin
        if (we) cells[waddr] <= wdata;
    end

    always_ff @(posedge clk) begin
        if (rst)     rdata <= '0;
        else if (re) rdata <= cells[raddr];
    end

endmodule

// File: rtl/stk_flags.sv
module stk_flags
    import stk_pkg::*;
(
    input  logic       clk,
    input  logic       rst,
    input  stk_op_e    op,
    output stk_flags_t flags
);

    always_ff @(posedge clk) begin
        if (rst) flags <= '0;
        else     flags <= stk_flags_of(op);
    end

endmodule

// File: rtl/desc_stack.sv
module desc_stack
    import stk_pkg::*;
#(
    parameter int PTR_W  = STK_PTR_W_DEF,
    parameter int DATA_W = STK_DATA_W_DEF
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              push_i,
    input  logic              pop_i,
    input  logic [DATA_W-1:0] wdata_i,
    input  logic              load_i,
    input  logic [PTR_W-1:0]  load_val_i,
    output logic [PTR_W-1:0]  ptr_o,
    output logic [DATA_W-1:0] rdata_o,
    output logic              rvalid_o,
    output logic              underflow_o,
    output logic              conflict_o
);

    stk_op_e          op;
    stk_flags_t       flags;
    logic [PTR_W-1:0] ptr;
    logic [PTR_W-1:0] ptr_up;
    logic             empty;

    assign op = stk_classify(push_i, pop_i, load_i, empty);

    stk_ptr_ctrl #(.PTR_W(PTR_W)) u_ptr (
        .clk      (clk),
        .rst      (rst),
        .op       (op),
        .load_val (load_val_i),
        .ptr      (ptr),
        .ptr_up   (ptr_up),
        .empty    (empty)
    );

    // Write at the current pointer; read at the pointer plus one
    stk_mem #(.DATA_W(DATA_W), .ADDR_W(PTR_W)) u_mem (
        .clk   (clk),
        .rst   (rst),
        .we    (op == OP_PUSH),
        .waddr (ptr),
        .wdata (wdata_i),
        .re    (op == OP_POP),
        .raddr (ptr_up),
        .rdata (rdata_o)
    );

    stk_flags u_flags (
        .clk   (clk),
        .rst   (rst),
        .op    (op),
        .flags (flags)
    );

    assign ptr_o       = ptr;
    assign rvalid_o    = flags.rd_valid;
    assign underflow_o = flags.underflow;
    assign conflict_o  = flags.clash;

endmodule

// File: rtl/stk_chk.sv
module stk_chk #(
    parameter int PTR_W  = 8,
    parameter int DATA_W = 8
) (
    input logic              clk,
    input logic              rst,
    input logic              push_i,
    input logic              pop_i,
    input logic              load_i,
    input logic [PTR_W-1:0]  load_val_i,
    input logic [PTR_W-1:0]  ptr_o,
    input logic [DATA_W-1:0] rdata_o,
    input logic              rvalid_o,
    input logic              underflow_o,
    input logic              conflict_o
);

    localparam logic [PTR_W-1:0] TOP = '1;

    logic only_push, only_pop, only_load, idle, multi;
    assign only_push = push_i && !pop_i && !load_i;
    assign only_pop  = pop_i && !push_i && !load_i;
    assign only_load = load_i && !push_i && !pop_i;
    assign idle      = !push_i && !pop_i && !load_i;
    assign multi     = (int'(push_i) + int'(pop_i) + int'(load_i)) > 1;

    AST_RESET_EMPTY: assert property (@(posedge clk) disable iff (rst)
        $fell(rst) |-> (ptr_o == TOP && !rvalid_o && !underflow_o && !conflict_o)); // R1

    AST_PUSH_DEC: assert property (@(posedge clk) disable iff (rst)
        only_push |=> (ptr_o == $past(ptr_o) - PTR_W'(1)) && !conflict_o); // R2

    AST_POP_INC: assert property (@(posedge clk) disable iff (rst)
        (only_pop && ptr_o != TOP) |=> (ptr_o == $past(ptr_o) + PTR_W'(1)) && rvalid_o); // R3

    AST_NO_UNDERFLOW_WRAP: assert property (@(posedge clk) disable iff (rst)
        (only_pop && ptr_o == TOP) |=> underflow_o && !rvalid_o && $stable(ptr_o)); // R5

    AST_CLASH_HOLD: assert property (@(posedge clk) disable iff (rst)
        multi |=> conflict_o && !rvalid_o && $stable(ptr_o)); // R6

    AST_LOAD_PTR: assert property (@(posedge clk) disable iff (rst)
        only_load |=> (ptr_o == $past(load_val_i)) && !underflow_o && !conflict_o); // R7

    AST_PUSH_WRAP: assert property (@(posedge clk) disable iff (rst)
        (only_push && ptr_o == '0) |=> ptr_o == TOP && !underflow_o); // R8

    AST_IDLE_QUIET: assert property (@(posedge clk) disable iff (rst)
        idle |=> $stable(ptr_o) && $stable(rdata_o) && !rvalid_o && !underflow_o && !conflict_o); // R9

endmodule

bind desc_stack stk_chk #(.PTR_W(PTR_W), .DATA_W(DATA_W)) u_chk (
    .clk         (clk),
    .rst         (rst),
    .push_i      (push_i),
    .pop_i       (pop_i),
    .load_i      (load_i),
    .load_val_i  (load_val_i),
    .ptr_o       (ptr_o),
    .rdata_o     (rdata_o),
    .rvalid_o    (rvalid_o),
    .underflow_o (underflow_o),
    .conflict_o  (conflict_o)
);

// File: tb/desc_stack_tb_top.sv
module desc_stack_tb_top;

    localparam int PTR_W  = 8;
    localparam int DATA_W = 8;

    logic              clk = 1'b0;
    logic              rst = 1'b1;
    logic              push_i = 1'b0;
    logic              pop_i = 1'b0;
    logic              load_i = 1'b0;
    logic [DATA_W-1:0] wdata_i = '0;
    logic [PTR_W-1:0]  load_val_i = '0;
    logic [PTR_W-1:0]  ptr_o;
    logic [DATA_W-1:0] rdata_o;
    logic              rvalid_o;
    logic              underflow_o;
    logic              conflict_o;

    int n_vec = 0;
    int n_bad = 0;

    always #10 clk = ~clk;

    desc_stack #(.PTR_W(PTR_W), .DATA_W(DATA_W)) dut_i (
        .clk         (clk),
        .rst         (rst),
        .push_i      (push_i),
        .pop_i       (pop_i),
        .wdata_i     (wdata_i),
        .load_i      (load_i),
        .load_val_i  (load_val_i),
        .ptr_o       (ptr_o),
        .rdata_o     (rdata_o),
        .rvalid_o    (rvalid_o),
        .underflow_o (underflow_o),
        .conflict_o  (conflict_o)
    );

    task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
        n_vec++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
        end
    endtask

    // Called at a falling edge; drives for one rising edge, returns at the next falling edge
    task automatic step(input logic pu, input logic po, input logic ld,
                        input logic [DATA_W-1:0] wd, input logic [PTR_W-1:0] lv);
        push_i = pu; pop_i = po; load_i = ld; wdata_i = wd; load_val_i = lv;
        @(negedge clk);
        push_i = 1'b0; pop_i = 1'b0; load_i = 1'b0;
    endtask

    task automatic flags_chk(input string tag, input logic v, input logic u, input logic c);
        chk({tag, " rvalid"}, 32'(rvalid_o), 32'(v));
        chk({tag, " underflow"}, 32'(underflow_o), 32'(u));
        chk({tag, " conflict"}, 32'(conflict_o), 32'(c));
    endtask

    task automatic t_reset();
        chk("R1 ptr in reset", 32'(ptr_o), 32'hFF);
        rst = 1'b0;
        @(negedge clk);
        chk("R1 ptr after reset", 32'(ptr_o), 32'hFF);
        chk("R1 rdata after reset", 32'(rdata_o), 32'h0);
        flags_chk("R1", 1'b0, 1'b0, 1'b0);
    endtask

    task automatic t_lifo();
        step(1, 0, 0, 8'hAB, '0);
        chk("R2 ptr after 1st push", 32'(ptr_o), 32'hFE);
        step(1, 0, 0, 8'hCD, '0);
        step(1, 0, 0, 8'hEF, '0);
        chk("R4 ptr after 3 pushes", 32'(ptr_o), 32'hFC);
        step(0, 1, 0, '0, '0);
        chk("R3 pop data EF", 32'(rdata_o), 32'hEF);
        chk("R3 ptr after pop", 32'(ptr_o), 32'hFD);
        flags_chk("R3 pop", 1'b1, 1'b0, 1'b0);
        step(0, 0, 0, '0, '0);
        chk("R3 rvalid single cycle", 32'(rvalid_o), 32'h0);
        chk("R9 rdata held on idle", 32'(rdata_o), 32'hEF);
        chk("R9 ptr held on idle", 32'(ptr_o), 32'hFD);
        step(0, 1, 0, '0, '0);
        chk("R4 pop data CD", 32'(rdata_o), 32'hCD);
        step(0, 1, 0, '0, '0);
        chk("R4 pop data AB", 32'(rdata_o), 32'hAB);
        chk("R4 ptr back to top", 32'(ptr_o), 32'hFF);
    endtask

    task automatic t_underflow();
        step(0, 1, 0, '0, '0);
        chk("R5 ptr held on empty pop", 32'(ptr_o), 32'hFF);
        flags_chk("R5", 1'b0, 1'b1, 1'b0);
        chk("R5 rdata unchanged", 32'(rdata_o), 32'hAB);
        step(0, 0, 0, '0, '0);
        chk("R5 underflow single cycle", 32'(underflow_o), 32'h0);
    endtask

    task automatic t_conflict();
        step(1, 0, 0, 8'h11, '0);
        step(1, 0, 0, 8'h22, '0);
        step(0, 1, 0, '0, '0);
        chk("R6 setup pop 22", 32'(rdata_o), 32'h22);
        chk("R6 setup ptr", 32'(ptr_o), 32'hFE);
        step(1, 1, 0, 8'h99, '0);
        chk("R6 ptr held push+pop", 32'(ptr_o), 32'hFE);
        flags_chk("R6 push+pop", 1'b0, 1'b0, 1'b1);
        step(1, 0, 1, 8'h77, 8'h40);
        chk("R6 ptr held push+load", 32'(ptr_o), 32'hFE);
        chk("R6 conflict push+load", 32'(conflict_o), 32'h1);
        step(0, 1, 1, '0, 8'h40);
        chk("R6 ptr held pop+load", 32'(ptr_o), 32'hFE);
        chk("R6 conflict pop+load", 32'(conflict_o), 32'h1);
        step(0, 0, 1, '0, 8'hFD);
        step(0, 1, 0, '0, '0);
        chk("R6 memory untouched by refused push", 32'(rdata_o), 32'h22);
    endtask

    task automatic t_load();
        step(0, 0, 1, '0, 8'h80);
        chk("R7 ptr loaded", 32'(ptr_o), 32'h80);
        flags_chk("R7", 1'b0, 1'b0, 1'b0);
        step(1, 0, 0, 8'h5C, '0);
        chk("R7 push after load", 32'(ptr_o), 32'h7F);
        step(0, 1, 0, '0, '0);
        chk("R7 pop after load data", 32'(rdata_o), 32'h5C);
        chk("R7 pop after load ptr", 32'(ptr_o), 32'h80);
    endtask

    task automatic t_wrap();
        step(0, 0, 1, '0, 8'h00);
        step(1, 0, 0, 8'h5A, '0);
        chk("R8 ptr wraps to top", 32'(ptr_o), 32'hFF);
        flags_chk("R8", 1'b0, 1'b0, 1'b0);
        step(0, 1, 0, '0, '0);
        chk("R8 pop after wrap is underflow", 32'(underflow_o), 32'h1);
    endtask

    task automatic t_fill();
        logic [DATA_W-1:0] pat;
        int bad_data = 0;
        step(0, 0, 1, '0, 8'hFF);
        for (int i = 0; i < 255; i++) begin
            pat = DATA_W'(i * 7 + 3);
            step(1, 0, 0, pat, '0);
        end
        chk("R2 ptr after 255 pushes", 32'(ptr_o), 32'h00);
        for (int k = 0; k < 255; k++) begin
            pat = DATA_W'((254 - k) * 7 + 3);
            step(0, 1, 0, '0, '0);
            if (rdata_o !== pat || rvalid_o !== 1'b1) begin
                bad_data++;
                if (bad_data == 1) chk("R4 deep pop data", 32'(rdata_o), 32'(pat));
            end
        end
        if (bad_data == 0) chk("R4 deep pop data", 32'h0, 32'h0);
        chk("R4 ptr after draining", 32'(ptr_o), 32'hFF);
        step(0, 1, 0, '0, '0);
        chk("R5 underflow after draining", 32'(underflow_o), 32'h1);
    endtask

    task automatic finish_run();
        $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
        $finish;
    endtask

    initial begin
        repeat (3) @(negedge clk);
        t_reset();
        t_lifo();
        t_underflow();
        t_conflict();
        t_load();
        t_wrap();
        t_fill();
        step(0, 0, 0, '0, '0);
        finish_run();
    end

    initial begin
        repeat (200000) @(posedge clk);
        n_vec++;
        n_bad++;
        $display("FAIL watchdog: run did not complete actual=hung expected=done");
        finish_run();
    end

endmodule